// File: doc/BRIEF.md
# Host Control Input Conditioner

This block prepares four asynchronous control lines arriving from a host at a printer-side parallel port so that the internal handshake and interrupt logic can use them safely. Each line is first brought into the internal clock domain through a chain of flip-flops. It then passes through its own small glitch-rejecting state machine. A level change gets through that machine only when two consecutive synchronized samples agree.

A single run-time control input, `filt_en`, chooses for all four lines at once between the filtered levels and the merely synchronized levels. The choice does not depend on any handshake mode, and the filter costs exactly one extra clock of latency. The block drives the selected clean levels, plus a one-clock rising-event pulse and a one-clock falling-event pulse per line, to the logic downstream.

Each glitch filter is a four-state machine: `ST_STEADY_LO`, `ST_STEADY_HI`, `ST_TRY_HI` (a low level is accepted and the last sample was high) and `ST_TRY_LO` (a high level is accepted and the last sample was low). The transitions are named as follows. From a steady state, a sample that differs from the accepted level moves the machine to the matching try state ("probe"). From a try state, a second matching sample moves it to the opposite steady state ("accept"). From a try state, a sample that matches the old level returns it to its steady state ("reject"). In a try state the output follows the current sample; in a steady state it holds the accepted level.

Top module: `host_ctl_conditioner`

## Requirements
- R1: While reset is held, and in the first cycles after its release with all pins high, every level output is 1 and no rise or fall pulse is asserted.
- R2: The pin vector is indexed bit 0 select-in, bit 1 strobe, bit 2 auto-feed, bit 3 init, and the output bits use the same order. With `filt_en` low, a pin change set up before clock edge k shows on `lvl_o` right after edge k+1.
- R3: With `filt_en` high, the same pin change shows on `lvl_o` right after edge k+2, exactly one clock later than in R2.
- R4: With `filt_en` high, a pin pulse captured by only one clock edge never changes `lvl_o` and raises no event.
- R5: With `filt_en` low, a pin pulse captured by one clock edge appears on `lvl_o` for exactly one cycle, with a fall pulse followed by a rise pulse.
- R6: A `rise_o` bit is high for exactly one cycle: the first cycle in which the matching level output reads 1 after reading 0.
- R7: A `fall_o` bit is high for exactly one cycle: the first cycle in which the matching level output reads 0 after reading 1.
- R8: The four lines are conditioned independently, so simultaneous changes on several pins give the correct per-bit levels and events.
- R9: Changing `filt_en` while the pins are stable changes no level and raises no event.
- R10: While `filt_en` is held, every change of a level output comes with exactly one event on that bit, and no event occurs without a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 selects the filtered levels, 0 selects the synchronized-only levels |
| pin_i | input | NUM_IN (4) | Raw host control pins: bit 0 select-in, 1 strobe, 2 auto-feed, 3 init |
| lvl_o | output | NUM_IN (4) | Selected clean levels |
| rise_o | output | NUM_IN (4) | One-cycle rising-event pulses |
| fall_o | output | NUM_IN (4) | One-cycle falling-event pulses |

## Verification
The assertions check on every cycle that a rise pulse only appears with a high level and a fall pulse only with a low level. They also check that, while the enable is held, every level change is paired with exactly one event and pulses never repeat on consecutive cycles. In filtered mode, they check that a level change occurs only when the synchronized sample has held for two cycles. The exact latency in each mode, the swallowing or passing of a one-edge pulse, the bit order, and the absence of events when the enable is toggled over quiet pins all depend on precisely timed stimulus, so only the bench's directed scenarios can show them.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

    // Glitch filter state: accepted level plus whether the last sample disagreed
    typedef enum logic [1:0] {
        ST_STEADY_LO = 2'b00,
        ST_STEADY_HI = 2'b01,
        ST_TRY_HI    = 2'b10,
        ST_TRY_LO    = 2'b11
    } flt_state_e;

    localparam int unsigned HCC_DEF_LINES  = 4;
    localparam int unsigned HCC_DEF_STAGES = 2;

endpackage

// File: rtl/hcc_sync_chain.sv
module hcc_sync_chain #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/hcc_glitch_fsm.sv
module hcc_glitch_fsm
    import hcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    output logic clean_o
);
    flt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STEADY_HI;
        else        state_q <= state_d;
    end

    // next state: probe, accept, reject
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY_LO: state_d = sample_i ? ST_TRY_HI    : ST_STEADY_LO;
            ST_STEADY_HI: state_d = sample_i ? ST_STEADY_HI : ST_TRY_LO;
            ST_TRY_HI:    state_d = sample_i ? ST_STEADY_HI : ST_STEADY_LO;
            ST_TRY_LO:    state_d = sample_i ? ST_STEADY_HI : ST_STEADY_LO;
            default:      state_d = ST_STEADY_HI;
        endcase
    end

    // outputs: a try state passes the sample, since a match there is the second in a row
    always_comb begin
        clean_o = 1'b1;
        unique case (state_q)
            ST_STEADY_LO: clean_o = 1'b0;
            ST_STEADY_HI: clean_o = 1'b1;
            ST_TRY_HI:    clean_o = sample_i;
            ST_TRY_LO:    clean_o = sample_i;
            default:      clean_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/hcc_edge_detect.sv
module hcc_edge_detect #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_filt_i,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] filt_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    // Each path keeps its own history, so switching paths never fakes an edge
    logic [WIDTH-1:0] sync_q, filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            filt_q <= '1;
        end else begin
            sync_q <= sync_i;
            filt_q <= filt_i;
        end
    end

    always_comb begin
        if (use_filt_i) begin
            lvl_o  = filt_i;
            rise_o = filt_i & ~filt_q;
            fall_o = ~filt_i & filt_q;
        end else begin
            lvl_o  = sync_i;
            rise_o = sync_i & ~sync_q;
            fall_o = ~sync_i & sync_q;
        end
    end

endmodule

// File: rtl/host_ctl_conditioner.sv
module host_ctl_conditioner
    import hcc_pkg::*;
#(
    parameter int unsigned NUM_IN      = HCC_DEF_LINES,
    parameter int unsigned SYNC_STAGES = HCC_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic [NUM_IN-1:0] pin_i,
    output logic [NUM_IN-1:0] lvl_o,
    output logic [NUM_IN-1:0] rise_o,
    output logic [NUM_IN-1:0] fall_o
);
    logic [NUM_IN-1:0] sync_lvl;
    logic [NUM_IN-1:0] filt_lvl;

    hcc_sync_chain #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_lvl)
    );

    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        hcc_glitch_fsm u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (sync_lvl[g]),
            .clean_o  (filt_lvl[g])
        );
    end

    hcc_edge_detect #(
        .WIDTH (NUM_IN)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_filt_i (filt_en),
        .sync_i     (sync_lvl),
        .filt_i     (filt_lvl),
        .lvl_o      (lvl_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o)
    );

endmodule

// File: rtl/host_ctl_conditioner_chk.sv
module host_ctl_conditioner_chk #(
    parameter int unsigned NUM_IN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              filt_en,
    input logic [NUM_IN-1:0] lvl_o,
    input logic [NUM_IN-1:0] rise_o,
    input logic [NUM_IN-1:0] fall_o,
    input logic [NUM_IN-1:0] sync_lvl
);
    assert_rise_level_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & ~lvl_o) == '0);

    assert_fall_level_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o & lvl_o) == '0);

    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(filt_en) |-> (rise_o & $past(rise_o)) == '0);

    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(filt_en) |-> (fall_o & $past(fall_o)) == '0);

    assert_event_pairs_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(filt_en) |-> ((lvl_o ^ $past(lvl_o)) == (rise_o | fall_o)));

    assert_two_samples_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $past(filt_en)) |->
            ((lvl_o ^ $past(lvl_o)) & (sync_lvl ^ $past(sync_lvl))) == '0);

endmodule

bind host_ctl_conditioner host_ctl_conditioner_chk #(
    .NUM_IN (NUM_IN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .filt_en  (filt_en),
    .lvl_o    (lvl_o),
    .rise_o   (rise_o),
    .fall_o   (fall_o),
    .sync_lvl (sync_lvl)
);

// File: tb/host_ctl_conditioner_tb.sv
module host_ctl_conditioner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         filt_en = 1'b0;
    logic [N-1:0] pin = '1;
    logic [N-1:0] lvl, rise, fall;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_ctl_conditioner #(.NUM_IN(N)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .filt_en (filt_en),
        .pin_i   (pin),
        .lvl_o   (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req, logic [N-1:0] el, logic [N-1:0] er, logic [N-1:0] ef);
        chk(req, "lvl", lvl, el);
        chk(req, "rise", rise, er);
        chk(req, "fall", fall, ef);
    endtask

    task automatic settle();
        pin = '1;
        repeat (4) tick();
    endtask

    task automatic t_reset();
        tick(); tick();
        chk_all("R1", 4'b1111, 4'b0000, 4'b0000);
        rst_n = 1'b1;
        tick(); chk_all("R1", 4'b1111, 4'b0000, 4'b0000);
        tick(); chk_all("R1", 4'b1111, 4'b0000, 4'b0000);
    endtask

    task automatic t_bypass_latency();
        filt_en = 1'b0; settle();
        pin[1] = 1'b0;                  // strobe
        tick(); chk_all("R2", 4'b1111, 4'b0000, 4'b0000);
        tick(); chk_all("R2_R7", 4'b1101, 4'b0000, 4'b0010);
        tick(); chk_all("R7", 4'b1101, 4'b0000, 4'b0000);
        pin[1] = 1'b1;
        tick(); chk_all("R2", 4'b1101, 4'b0000, 4'b0000);
        tick(); chk_all("R2_R6", 4'b1111, 4'b0010, 4'b0000);
        tick(); chk_all("R6", 4'b1111, 4'b0000, 4'b0000);
    endtask

    task automatic t_filter_latency();
        filt_en = 1'b1; settle();
        pin[2] = 1'b0;                  // auto-feed
        tick(); chk_all("R3", 4'b1111, 4'b0000, 4'b0000);
        tick(); chk_all("R3_R10", 4'b1111, 4'b0000, 4'b0000);
        tick(); chk_all("R3_R7", 4'b1011, 4'b0000, 4'b0100);
        tick(); chk_all("R10", 4'b1011, 4'b0000, 4'b0000);
        pin[2] = 1'b1;
        tick(); tick(); chk_all("R3", 4'b1011, 4'b0000, 4'b0000);
        tick(); chk_all("R3_R6", 4'b1111, 4'b0100, 4'b0000);
        tick(); chk_all("R6", 4'b1111, 4'b0000, 4'b0000);
    endtask

    task automatic t_glitch_filtered();
        filt_en = 1'b1; settle();
        pin[0] = 1'b0;                  // select-in, one edge wide
        tick();
        pin[0] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(); chk_all("R4", 4'b1111, 4'b0000, 4'b0000);
        end
    endtask

    task automatic t_glitch_bypass();
        filt_en = 1'b0; settle();
        pin[3] = 1'b0;                  // init, one edge wide
        tick();
        pin[3] = 1'b1;
        tick(); chk_all("R5", 4'b0111, 4'b0000, 4'b1000);
        tick(); chk_all("R5", 4'b1111, 4'b1000, 4'b0000);
        tick(); chk_all("R5", 4'b1111, 4'b0000, 4'b0000);
    endtask

    task automatic t_independent();
        filt_en = 1'b0; settle();
        pin = 4'b0101;
        tick(); tick(); chk_all("R8", 4'b0101, 4'b0000, 4'b1010);
        pin = 4'b1001;
        tick(); tick(); chk_all("R8", 4'b1001, 4'b1000, 4'b0100);
        filt_en = 1'b1;
        repeat (3) tick();
        pin = 4'b0110;
        tick(); tick(); chk_all("R8_R3", 4'b1001, 4'b0000, 4'b0000);
        tick(); chk_all("R8_R3", 4'b0110, 4'b0110, 4'b1001);
        tick(); chk_all("R8", 4'b0110, 4'b0000, 4'b0000);
    endtask

    task automatic t_enable_toggle();
        filt_en = 1'b0; settle();
        for (int i = 0; i < 4; i++) begin
            filt_en = ~filt_en;
            #1; chk_all("R9", 4'b1111, 4'b0000, 4'b0000);
            tick(); chk_all("R9", 4'b1111, 4'b0000, 4'b0000);
        end
        pin = 4'b1010; repeat (4) tick();
        for (int i = 0; i < 4; i++) begin
            filt_en = ~filt_en;
            #1; chk_all("R9", 4'b1010, 4'b0000, 4'b0000);
            tick(); chk_all("R9", 4'b1010, 4'b0000, 4'b0000);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_bypass_latency();
        t_filter_latency();
        t_glitch_filtered();
        t_glitch_bypass();
        t_independent();
        t_enable_toggle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule